// File: doc/BRIEF.md
# Double-Column Sparse Hit Readout

This block drains pixel hits from one double column of a pixel matrix toward the chip periphery. The column is divided into pixel groups, eight pixels per group (a 4 by 2 patch) and 64 groups per column. Each pixel that has a hit raises a request and holds its 28-bit timing payload until the block acknowledges it. Only pixels with a hit ever produce traffic, so the readout is sparse. It also runs continuously while acquisition goes on.

Each group has a two-entry local buffer. It loads one pending pixel per clock and tags the entry with the pixel's position inside the group. A circulating token gives the shared column bus to at most one group that holds data in each cycle. The token passes over empty groups within that same cycle, so idle groups cost no bus time. Granted entries move into a four-entry end-of-column buffer. That buffer presents 44-bit packets, carrying a 16-bit pixel coordinate and the payload, to the periphery through a valid/ready pair. A full end-of-column buffer holds the token back, and a full group buffer stops acknowledging its pixels.

Top module: `dcr_column`

## Requirements
- R1: While reset is high and in the first cycle after it, `pkt_valid` is low, every buffer is empty and the token search starts from group 0.
- R2: A packet is laid out as `pkt_data[43:37]` = `col_addr`, `[36:31]` = group index (0 to 63), `[30:28]` = pixel index inside the group (0 to 7), `[27:0]` = the payload the pixel held on `hit_data`.
- R3: A group loads at most one pixel per cycle. Among its requesting pixels it picks the lowest index. The chosen pixel's `hit_ack` bit is high in the cycle whose closing edge captures its data. No bit of `hit_ack` is high without its request.
- R4: A group buffer holds two entries. While it holds two, none of that group's pixels is acknowledged, even in a cycle where the token drains it.
- R5: At most one group is granted per cycle, and only a group holding data. The search begins at the group after the last one served, wraps from 63 to 0, and passes over empty groups in the same cycle.
- R6: The end-of-column buffer holds four packets. While it holds four, no group is granted.
- R7: While `pkt_valid` is high and `pkt_ready` low, `pkt_valid` stays high and `pkt_data` stays unchanged. A packet leaves on an edge where both are high. Packets leave in the order they were granted.
- R8: With all buffers empty, a hit whose `hit_ack` is high in cycle c shows up on the output with `pkt_valid` high in cycle c+2.
- R9: With no pixel requesting, no packet is ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column readout clock |
| rst | input | 1 | Synchronous reset, active high |
| col_addr | input | 7 | Index of this double column, copied into every packet |
| hit_req | input | 512 | One request per pixel, bit g*8+p for pixel p of group g, held until acknowledged |
| hit_data | input | 14336 | 28-bit payload per pixel, field g*8+p, stable while its request is high |
| hit_ack | output | 512 | Pixel whose data is captured at the end of this cycle |
| pkt_valid | output | 1 | End-of-column buffer holds a packet |
| pkt_data | output | 44 | Oldest packet: coordinate and payload |
| pkt_ready | input | 1 | Periphery takes the packet on this edge |

## Verification
The checker watches several rules on every cycle. It holds the output packet steady under back-pressure. It lets no acknowledge go out without its request, and no group takes more than one pixel per cycle. A full group never acknowledges a pixel. It also checks that there is at most one grant, that every grant goes to a group holding data, and that nothing is granted while the column buffer is full. Only the directed scenarios can show that the grants actually come in the fair rotating order with wrap-around. They also show the exact two-cycle hit-to-output latency and the coordinate bit layout. Finally they show that a stalled column resumes with the group after the last one served rather than with the group that was blocked.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  // total width of the pixel coordinate carried in each packet
  localparam int COORD_W = 16;

  // pointer width for a FIFO of the given depth (at least one bit)
  function automatic int ptr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/dcr_grp_buf.sv
module dcr_grp_buf #(
  parameter int PIX_N = 8,
  parameter int DEPTH = 2,
  parameter int PAY_W = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PIX_N-1:0]         req,
  input  logic [PIX_N*PAY_W-1:0]   data,
  output logic [PIX_N-1:0]         ack,
  input  logic                     pop,
  output logic                     not_empty,
  output logic                     full,
  output logic [$clog2(PIX_N)-1:0] head_pix,
  output logic [PAY_W-1:0]         head_pay
);
  localparam int PIX_W = $clog2(PIX_N);
  localparam int PTR_W = dcr_pkg::ptr_w(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [PIX_W-1:0] pix;
    logic [PAY_W-1:0] pay;
  } ent_t;

  ent_t             mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             found;
  logic [PIX_W-1:0] sel;
  logic             load;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // fixed priority: lowest requesting pixel wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < PIX_N; i++) begin
      if (!found && req[i]) begin
        found = 1'b1;
        sel   = PIX_W'(i);
      end
    end
  end

  assign full      = (cnt == CNT_W'(DEPTH));
  assign not_empty = (cnt != '0);
  assign load      = found && !full;
  assign ack       = load ? (PIX_N'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (load) mem[wp] <= '{pix: sel, pay: data[sel*PAY_W +: PAY_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (load) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({load, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_pix = mem[rp].pix;
  assign head_pay = mem[rp].pay;
endmodule

// File: rtl/dcr_token_arb.sv
module dcr_token_arb #(
  parameter int N = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 enable,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_valid
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] ptr;
  int               j;

  // rotating search from ptr, passing over empty groups in one cycle
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    j         = 0;
    for (int i = 0; i < N; i++) begin
      j = int'(ptr) + i;
      if (j >= N) j = j - N;
      if (!gnt_valid && enable && req[j]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IDX_W'(j);
      end
    end
  end

  assign gnt = gnt_valid ? (N'(1) << gnt_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (gnt_valid) begin
      ptr <= (gnt_idx == IDX_W'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/dcr_eoc_fifo.sv
module dcr_eoc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         room,
  output logic         valid,
  output logic [W-1:0] rdata,
  input  logic         ready
);
  localparam int PTR_W = dcr_pkg::ptr_w(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             rd;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid = (cnt != '0);
  assign room  = (cnt < CNT_W'(DEPTH));
  assign rd    = valid && ready;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= step(wp);
      if (rd) rp <= step(rp);
      case ({wr, rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rp];
endmodule

// File: rtl/dcr_column.sv
module dcr_column #(
  parameter int N_GRP     = 64,
  parameter int PIX_N     = 8,
  parameter int GRP_DEPTH = 2,
  parameter int EOC_DEPTH = 4,
  parameter int PAY_W     = 28,
  localparam int GRP_W    = $clog2(N_GRP),
  localparam int PIX_W    = $clog2(PIX_N),
  localparam int COL_W    = dcr_pkg::COORD_W - GRP_W - PIX_W,
  localparam int NPIX     = N_GRP * PIX_N,
  localparam int PKT_W    = dcr_pkg::COORD_W + PAY_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [COL_W-1:0]       col_addr,
  input  logic [NPIX-1:0]        hit_req,
  input  logic [NPIX*PAY_W-1:0]  hit_data,
  output logic [NPIX-1:0]        hit_ack,
  output logic                   pkt_valid,
  output logic [PKT_W-1:0]       pkt_data,
  input  logic                   pkt_ready
);
  logic [N_GRP-1:0] grp_ne;
  logic [N_GRP-1:0] grp_full;
  logic [N_GRP-1:0] gnt_vec;
  logic [GRP_W-1:0] gnt_idx;
  logic             gnt_valid;
  logic             eoc_room;
  logic [PIX_W-1:0] head_pix [N_GRP];
  logic [PAY_W-1:0] head_pay [N_GRP];
  logic [PKT_W-1:0] bus_pkt;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    dcr_grp_buf #(
      .PIX_N (PIX_N),
      .DEPTH (GRP_DEPTH),
      .PAY_W (PAY_W)
    ) u_buf (
      .clk       (clk),
      .rst       (rst),
      .req       (hit_req[g*PIX_N +: PIX_N]),
      .data      (hit_data[g*PIX_N*PAY_W +: PIX_N*PAY_W]),
      .ack       (hit_ack[g*PIX_N +: PIX_N]),
      .pop       (gnt_vec[g]),
      .not_empty (grp_ne[g]),
      .full      (grp_full[g]),
      .head_pix  (head_pix[g]),
      .head_pay  (head_pay[g])
    );
  end

  dcr_token_arb #(.N(N_GRP)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (grp_ne),
    .enable    (eoc_room),
    .gnt       (gnt_vec),
    .gnt_idx   (gnt_idx),
    .gnt_valid (gnt_valid)
  );

  // column bus: coordinate of the granted entry plus its payload
  assign bus_pkt = {col_addr, gnt_idx, head_pix[gnt_idx], head_pay[gnt_idx]};

  dcr_eoc_fifo #(.DEPTH(EOC_DEPTH), .W(PKT_W)) u_eoc (
    .clk   (clk),
    .rst   (rst),
    .wr    (gnt_valid),
    .wdata (bus_pkt),
    .room  (eoc_room),
    .valid (pkt_valid),
    .rdata (pkt_data),
    .ready (pkt_ready)
  );
endmodule

// File: rtl/dcr_column_chk.sv
module dcr_column_chk #(
  parameter int N_GRP = 64,
  parameter int PIX_N = 8,
  parameter int PKT_W = 44
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_GRP*PIX_N-1:0] hit_req,
  input logic [N_GRP*PIX_N-1:0] hit_ack,
  input logic                   pkt_valid,
  input logic                   pkt_ready,
  input logic [PKT_W-1:0]       pkt_data,
  input logic [N_GRP-1:0]       gnt,
  input logic [N_GRP-1:0]       grp_ne,
  input logic [N_GRP-1:0]       grp_full,
  input logic                   eoc_room
);
  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> !pkt_valid);

  assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_ack & ~hit_req) == '0);

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    assert_one_load_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_ack[g*PIX_N +: PIX_N]));
    assert_full_no_ack_R4: assert property (@(posedge clk) disable iff (rst)
      grp_full[g] |-> hit_ack[g*PIX_N +: PIX_N] == '0);
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_grant_has_data_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~grp_ne) == '0);

  assert_no_grant_full_R6: assert property (@(posedge clk) disable iff (rst)
    !eoc_room |-> gnt == '0);

  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data));
endmodule

bind dcr_column dcr_column_chk #(
  .N_GRP (N_GRP),
  .PIX_N (PIX_N),
  .PKT_W (PKT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hit_req   (hit_req),
  .hit_ack   (hit_ack),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .pkt_data  (pkt_data),
  .gnt       (gnt_vec),
  .grp_ne    (grp_ne),
  .grp_full  (grp_full),
  .eoc_room  (eoc_room)
);

// File: tb/dcr_column_bench.sv
`timescale 1ns/1ps
module dcr_column_bench;
  localparam int NG    = 64;
  localparam int NP    = 8;
  localparam int PW    = 28;
  localparam int NPIX  = NG * NP;
  localparam logic [6:0] COL = 7'h5A;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [6:0]        col_addr = COL;
  logic [NPIX-1:0]   hit_req;
  logic [NPIX*PW-1:0] hit_data;
  logic [NPIX-1:0]   hit_ack;
  logic              pkt_valid;
  logic [43:0]       pkt_data;
  logic              pkt_ready = 1'b1;
  logic [NPIX-1:0]   arm = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [43:0] exp_q [0:15];

  always #2.5 clk = ~clk;

  dcr_column u_dcr_column (
    .clk (clk), .rst (rst), .col_addr (col_addr),
    .hit_req (hit_req), .hit_data (hit_data), .hit_ack (hit_ack),
    .pkt_valid (pkt_valid), .pkt_data (pkt_data), .pkt_ready (pkt_ready)
  );

  // pixel model: request held until acknowledged
  always @(posedge clk) begin
    if (rst) hit_req <= '0;
    else     hit_req <= (hit_req & ~hit_ack) | arm;
  end

  function automatic logic [PW-1:0] pay(input int g, input int p);
    return PW'(32'h0A50000 + g * 1031 + p * 77);
  endfunction

  function automatic logic [43:0] mk(input int g, input int p);
    return {COL, 6'(g), 3'(p), pay(g, p)};
  endfunction

  initial begin
    for (int g = 0; g < NG; g++)
      for (int p = 0; p < NP; p++)
        hit_data[(g*NP+p)*PW +: PW] = pay(g, p);
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic fire(input logic [NPIX-1:0] mask);
    @(negedge clk);
    arm = mask;
    @(posedge clk);
    #1 arm = '0;
  endtask

  function automatic logic [NPIX-1:0] bit_of(input int g, input int p);
    return NPIX'(1) << (g * NP + p);
  endfunction

  task automatic collect(input int n, input string rq);
    for (int k = 0; k < n; k++) begin
      int t;
      @(negedge clk);
      pkt_ready = 1'b1;
      t = 0;
      while (!pkt_valid && t < 300) begin
        @(negedge clk);
        t++;
      end
      chk(pkt_valid && pkt_data == exp_q[k], rq, $sformatf("packet %0d", k),
          64'(pkt_data), 64'(exp_q[k]));
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!pkt_valid, "R1", "valid in reset", 64'(pkt_valid), 0);
    chk(hit_ack == '0, "R1", "ack in reset", 64'(hit_ack[63:0]), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pkt_valid, "R1", "valid after reset", 64'(pkt_valid), 0);
  endtask

  task automatic t_single;
    fire(bit_of(10, 5));
    @(negedge clk);
    chk(hit_ack[10*NP +: NP] == 8'h20, "R3", "single ack", 64'(hit_ack[10*NP +: NP]), 64'h20);
    chk(!pkt_valid, "R8", "valid at c", 64'(pkt_valid), 0);
    @(negedge clk);
    chk(!pkt_valid, "R8", "valid at c+1", 64'(pkt_valid), 0);
    @(negedge clk);
    chk(pkt_valid, "R8", "valid at c+2", 64'(pkt_valid), 1);
    chk(pkt_data == mk(10, 5), "R2", "packet layout", 64'(pkt_data), 64'(mk(10, 5)));
    @(negedge clk);
    chk(!pkt_valid, "R7", "drained", 64'(pkt_valid), 0);
  endtask

  task automatic t_priority;
    fire(bit_of(3, 1) | bit_of(3, 4) | bit_of(3, 6));
    @(negedge clk);
    chk(hit_ack[3*NP +: NP] == 8'h02, "R3", "first pick", 64'(hit_ack[3*NP +: NP]), 64'h02);
    @(negedge clk);
    chk(hit_ack[3*NP +: NP] == 8'h10, "R3", "second pick", 64'(hit_ack[3*NP +: NP]), 64'h10);
    exp_q[0] = mk(3, 1); exp_q[1] = mk(3, 4); exp_q[2] = mk(3, 6);
    collect(3, "R3");
  endtask

  task automatic t_wrap;
    // last served group 3, so search starts at 4
    fire(bit_of(2, 0) | bit_of(9, 0) | bit_of(40, 0));
    exp_q[0] = mk(9, 0); exp_q[1] = mk(40, 0); exp_q[2] = mk(2, 0);
    collect(3, "R5");
  endtask

  task automatic t_fair;
    fire(bit_of(10, 0) | bit_of(10, 1) | bit_of(30, 0) | bit_of(30, 1));
    exp_q[0] = mk(10, 0); exp_q[1] = mk(30, 0);
    exp_q[2] = mk(10, 1); exp_q[3] = mk(30, 1);
    collect(4, "R5");
  endtask

  task automatic t_stall;
    logic [NPIX-1:0] m;
    @(negedge clk);
    pkt_ready = 1'b0;
    m = '0;
    for (int p = 0; p < NP; p++) m |= bit_of(7, p);
    fire(m);
    repeat (20) @(negedge clk);
    chk(hit_ack[7*NP+6] == 1'b0 && hit_req[7*NP+6], "R4", "full group acks",
        64'(hit_ack[7*NP +: NP]), 0);
    chk(pkt_valid && pkt_data == mk(7, 0), "R7", "stalled head", 64'(pkt_data), 64'(mk(7, 0)));
    repeat (5) @(negedge clk);
    chk(pkt_valid && pkt_data == mk(7, 0), "R7", "head held", 64'(pkt_data), 64'(mk(7, 0)));
    fire(bit_of(8, 0));
    repeat (5) @(negedge clk);
    chk(pkt_data == mk(7, 0) && hit_req[7*NP+6], "R6", "no grant while full",
        64'(pkt_data), 64'(mk(7, 0)));
    exp_q[0] = mk(7, 0); exp_q[1] = mk(7, 1); exp_q[2] = mk(7, 2);
    exp_q[3] = mk(7, 3); exp_q[4] = mk(8, 0); exp_q[5] = mk(7, 4);
    exp_q[6] = mk(7, 5); exp_q[7] = mk(7, 6); exp_q[8] = mk(7, 7);
    collect(9, "R6");
  endtask

  task automatic t_idle;
    bit seen;
    seen = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (pkt_valid) seen = 1'b1;
    end
    chk(!seen, "R9", "packet without hits", 64'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_priority();
    t_wrap();
    t_fair();
    t_stall();
    t_idle();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule